// File: doc/BRIEF.md
# DRAM Hard Row-Repair Command Sequencer

This block sits on the controller side of a DDR4-style memory channel. It takes one failing row and drives the command and address bus through the complete entry into hard row-repair mode. A single start pulse captures the failing bank group, bank, row and a write-flavour select. The block then checks three status flags. If every bank is idle and both DBI and CRC are off, it issues the mode-register write that enables hard repair, then the four guard keys to MR0, then the activate of the failing row and the final write. It signals completion with a one-cycle done pulse.

The spacing between commands is fixed by two cycle-count parameters: the mode-register gap and the activate-to-write gap. On every cycle where no command is issued, the block drives a deselect. If a precondition fails, the block raises a one-cycle error pulse and the bus stays quiet. The write flavour chooses between a write with auto-precharge, which is the form that keeps refresh usable for other banks, and a plain write.

Top module: `rrep_seq`

## Requirements
- R1: On a start with `banks_idle_i` low, `dbi_en_i` high or `crc_en_i` high, `err_o` is high for exactly the one cycle after the start edge. No command is issued and `done_o` stays low.
- R2: On an accepted start, the first command appears in the cycle after the second rising edge counted from the start edge. It is MRS (code 1) to MR4, selected by bg=2'b01 and ba=2'b00, with an address that has only bit 13 set. Bit 5 is therefore clear.
- R3: The next four commands are MRS to MR0 with bg=0 and ba=0. Address bits 6:0 are all ones and bits 17:12 are zero (parameter KEY_FILL=0).
- R4: On those four keys, address bits 11:7 carry 5'b11001, 5'b01111, 5'b10111 and 5'b00111, in that order.
- R5: From the MR4 write through the activate, each command follows the previous one by exactly T_MOD cycles, and only DES (code 0) appears between them.
- R6: The activate (ACT, code 2) carries the bank group, bank and row that were captured at the start edge.
- R7: The write follows the activate by exactly T_AW cycles and uses the same bank group and bank with a zero address. It is WRA (code 4) when `wra_mode_i` was 1 at start, and WR (code 3) when it was 0.
- R8: `done_o` is high for exactly one cycle: the cycle after the write.
- R9: A start pulse, or a change of the target inputs, while a sequence is running has no effect on the command stream.
- R10: When idle and after reset, the bus shows DES with zero bank group, bank and address, and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| wra_mode_i | input | 1 | 1 selects write with auto-precharge, 0 a plain write |
| tgt_bg_i | input | 2 | Failing bank group |
| tgt_ba_i | input | 2 | Failing bank |
| tgt_row_i | input | ADDR_W | Failing row address |
| banks_idle_i | input | 1 | All banks precharged and idle |
| dbi_en_i | input | 1 | DBI currently enabled |
| crc_en_i | input | 1 | Write CRC currently enabled |
| cmd_o | output | 3 | Command code: 0 DES, 1 MRS, 2 ACT, 3 WR, 4 WRA |
| bg_o | output | 2 | Bank group bus |
| ba_o | output | 2 | Bank bus |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | One-cycle pulse after the write |
| err_o | output | 1 | One-cycle pulse on a refused start |

## Verification
A wrong step index or a misloaded gap counter shows up on the bus at the next command. That command is then either the wrong type or arrives on the wrong cycle, so the fault is visible within one T_MOD window. If the captured target is corrupted, the fault shows only at the activate or the write, and a wrong write flavour shows only at the last command. For that reason the bench compares the whole trace cycle by cycle against an expected timeline. A bad precondition decode appears one cycle after the start, as a wrong error pulse or a stray MR4 write.

// File: rtl/rrep_pkg.sv
package rrep_pkg;
   typedef enum logic [2:0] {
      CMD_DES = 3'd0,
      CMD_MRS = 3'd1,
      CMD_ACT = 3'd2,
      CMD_WR  = 3'd3,
      CMD_WRA = 3'd4
   } rrep_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } rrep_state_e;

   localparam int STEP_W       = 3;
   localparam logic [2:0] STEP_MR4 = 3'd0;
   localparam logic [2:0] STEP_ACT = 3'd5;
   localparam logic [2:0] STEP_WR  = 3'd6;
   localparam int MR4_HARD_BIT = 13;

   // Guard-key pattern for address bits 11:7, indexed by sequence step 1..4.
   function automatic logic [4:0] guard_key(input logic [2:0] step);
      case (step)
         3'd1:    guard_key = 5'b11001;
         3'd2:    guard_key = 5'b01111;
         3'd3:    guard_key = 5'b10111;
         3'd4:    guard_key = 5'b00111;
         default: guard_key = 5'b00000;
      endcase
   endfunction
endpackage

// File: rtl/rrep_gap_timer.sv
module rrep_gap_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rrep_payload.sv
module rrep_payload
   import rrep_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter bit KEY_FILL = 1'b0
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic [1:0]        tgt_bg_i,
   input  logic [1:0]        tgt_ba_i,
   input  logic [ADDR_W-1:0] tgt_row_i,
   input  logic              wra_i,
   output logic [2:0]        cmd_o,
   output logic [1:0]        bg_o,
   output logic [1:0]        ba_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_LSB = 12;

   logic [ADDR_W-1:0] hi_fill;

   generate
      if (KEY_FILL) begin : g_fill_ones
         assign hi_fill = {ADDR_W{1'b1}} << HI_LSB;
      end else begin : g_fill_zero
         assign hi_fill = '0;
      end
   endgenerate

   always_comb begin
      cmd_o  = CMD_DES;
      bg_o   = 2'b00;
      ba_o   = 2'b00;
      addr_o = '0;
      case (step_i)
         STEP_MR4: begin
            cmd_o                = CMD_MRS;
            bg_o                 = 2'b01;
            addr_o[MR4_HARD_BIT] = 1'b1;
         end
         3'd1, 3'd2, 3'd3, 3'd4: begin
            cmd_o        = CMD_MRS;
            addr_o       = hi_fill;
            addr_o[6:0]  = 7'h7F;
            addr_o[11:7] = guard_key(step_i);
         end
         STEP_ACT: begin
            cmd_o  = CMD_ACT;
            bg_o   = tgt_bg_i;
            ba_o   = tgt_ba_i;
            addr_o = tgt_row_i;
         end
         STEP_WR: begin
            cmd_o = wra_i ? CMD_WRA : CMD_WR;
            bg_o  = tgt_bg_i;
            ba_o  = tgt_ba_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rrep_seq.sv
module rrep_seq
   import rrep_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int T_MOD    = 24,
   parameter int T_AW     = 16,
   parameter bit KEY_FILL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wra_mode_i,
   input  logic [1:0]        tgt_bg_i,
   input  logic [1:0]        tgt_ba_i,
   input  logic [ADDR_W-1:0] tgt_row_i,
   input  logic              banks_idle_i,
   input  logic              dbi_en_i,
   input  logic              crc_en_i,
   output logic [2:0]        cmd_o,
   output logic [1:0]        bg_o,
   output logic [1:0]        ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              done_o,
   output logic              err_o
);
   localparam int GAP_MAX = (T_MOD > T_AW) ? T_MOD : T_AW;
   localparam int GAP_W   = $clog2(GAP_MAX + 1);

   generate
      if (ADDR_W < 14) begin : g_bad_addr_w
         $error("rrep_seq: ADDR_W must reach bit 13");
      end
      if (T_MOD < 1 || T_AW < 1) begin : g_bad_gap
         $error("rrep_seq: gaps must be at least one cycle");
      end
   endgenerate

   rrep_state_e       state_q;
   logic [STEP_W-1:0] step_q;
   logic [1:0]        bg_t_q, ba_t_q;
   logic [ADDR_W-1:0] row_t_q;
   logic              wra_t_q;

   logic              gap_zero, fire, accept, refuse, tmr_load;
   logic [GAP_W-1:0]  tmr_val;
   logic [2:0]        pl_cmd;
   logic [1:0]        pl_bg, pl_ba;
   logic [ADDR_W-1:0] pl_addr;

   wire pre_ok = banks_idle_i && !dbi_en_i && !crc_en_i;
   assign accept = (state_q == ST_IDLE) && start_i && pre_ok;
   assign refuse = (state_q == ST_IDLE) && start_i && !pre_ok;
   assign fire   = (state_q == ST_RUN) && gap_zero;

   assign tmr_load = accept || fire;
   assign tmr_val  = accept             ? '0 :
                     (step_q == STEP_ACT) ? GAP_W'(T_AW - 1) : GAP_W'(T_MOD - 1);

   rrep_gap_timer #(.CNT_W(GAP_W)) u_gap (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (gap_zero)
   );

   rrep_payload #(.ADDR_W(ADDR_W), .KEY_FILL(KEY_FILL)) u_payload (
      .step_i    (step_q),
      .tgt_bg_i  (bg_t_q),
      .tgt_ba_i  (ba_t_q),
      .tgt_row_i (row_t_q),
      .wra_i     (wra_t_q),
      .cmd_o     (pl_cmd),
      .bg_o      (pl_bg),
      .ba_o      (pl_ba),
      .addr_o    (pl_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= STEP_MR4;
         bg_t_q  <= '0;
         ba_t_q  <= '0;
         row_t_q <= '0;
         wra_t_q <= 1'b0;
         cmd_o   <= CMD_DES;
         bg_o    <= '0;
         ba_o    <= '0;
         addr_o  <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         cmd_o  <= CMD_DES;
         bg_o   <= '0;
         ba_o   <= '0;
         addr_o <= '0;
         done_o <= 1'b0;
         err_o  <= refuse;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_RUN;
                  step_q  <= STEP_MR4;
                  bg_t_q  <= tgt_bg_i;
                  ba_t_q  <= tgt_ba_i;
                  row_t_q <= tgt_row_i;
                  wra_t_q <= wra_mode_i;
               end
            end
            ST_RUN: begin
               if (fire) begin
                  cmd_o  <= pl_cmd;
                  bg_o   <= pl_bg;
                  ba_o   <= pl_ba;
                  addr_o <= pl_addr;
                  if (step_q == STEP_WR) begin
                     state_q <= ST_FIN;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_FIN: begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rrep_seq_chk.sv
module rrep_seq_chk
   import rrep_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int T_MOD  = 24,
   parameter int T_AW   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cmd_o,
   input logic [1:0]        bg_o,
   input logic [1:0]        ba_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              done_o,
   input logic              err_o
);
   localparam int GAP_MAX = (T_MOD > T_AW) ? T_MOD : T_AW;
   localparam int SW      = $clog2(GAP_MAX + 2) + 1;
   localparam logic [ADDR_W-1:0] MR4_VAL = ADDR_W'(1) << MR4_HARD_BIT;

   logic [SW-1:0] since_q;
   logic [2:0]    last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
         last_q  <= CMD_DES;
      end else if (cmd_o != CMD_DES) begin
         since_q <= SW'(1);
         last_q  <= cmd_o;
      end else if (since_q != {SW{1'b1}}) begin
         since_q <= since_q + 1'b1;
      end
   end

   p_mrs_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_MRS) |->
         ((bg_o == 2'b01 && ba_o == 2'b00 && addr_o == MR4_VAL) ||
          (bg_o == 2'b00 && ba_o == 2'b00 && addr_o[6:0] == 7'h7F)));

   p_mod_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != CMD_DES && last_q == CMD_MRS) |-> (since_q == SW'(T_MOD)));

   p_act_to_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != CMD_DES && last_q == CMD_ACT) |->
         ((cmd_o == CMD_WR || cmd_o == CMD_WRA) && since_q == SW'(T_AW)));

   p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(cmd_o) == CMD_WR || $past(cmd_o) == CMD_WRA));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (cmd_o == CMD_DES && !done_o));

   p_cmd_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o <= CMD_WRA);
endmodule

bind rrep_seq rrep_seq_chk #(.ADDR_W(ADDR_W), .T_MOD(T_MOD), .T_AW(T_AW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cmd_o  (cmd_o),
   .bg_o   (bg_o),
   .ba_o   (ba_o),
   .addr_o (addr_o),
   .done_o (done_o),
   .err_o  (err_o)
);

// File: tb/rrep_seq_bench.sv
module rrep_seq_bench;
   localparam int AW = 18;
   localparam int TM = 12;
   localparam int TA = 6;
   localparam int K_ACT  = 2 + 5 * TM;
   localparam int K_WR   = K_ACT + TA;
   localparam int K_DONE = K_WR + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, wra = 1'b0;
   logic [1:0]    tbg = '0, tba = '0;
   logic [AW-1:0] trow = '0;
   logic          bidle = 1'b1, dbi = 1'b0, crc = 1'b0;
   logic [2:0]    cmd;
   logic [1:0]    bg, ba;
   logic [AW-1:0] addr;
   logic          done, err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rrep_seq #(.ADDR_W(AW), .T_MOD(TM), .T_AW(TA)) u_rrep_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .wra_mode_i(wra),
      .tgt_bg_i(tbg), .tgt_ba_i(tba), .tgt_row_i(trow),
      .banks_idle_i(bidle), .dbi_en_i(dbi), .crc_en_i(crc),
      .cmd_o(cmd), .bg_o(bg), .ba_o(ba), .addr_o(addr),
      .done_o(done), .err_o(err)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_key(input int i);
      case (i)
         1: return 5'b11001;
         2: return 5'b01111;
         3: return 5'b10111;
         default: return 5'b00111;
      endcase
   endfunction

   // Expected word {cmd, bg, ba, addr} on sample k of an accepted run.
   function automatic logic [AW+6:0] exp_word(input int k, input logic [1:0] g,
         input logic [1:0] b, input logic [AW-1:0] r, input bit m);
      logic [AW-1:0] a;
      a = '0;
      if (k == 2) begin
         a[13] = 1'b1;
         return {3'd1, 2'b01, 2'b00, a};
      end
      for (int i = 1; i <= 4; i++) begin
         if (k == 2 + i * TM) begin
            a[6:0]  = 7'h7F;
            a[11:7] = exp_key(i);
            return {3'd1, 2'b00, 2'b00, a};
         end
      end
      if (k == K_ACT) return {3'd2, g, b, r};
      if (k == K_WR)  return {(m ? 3'd4 : 3'd3), g, b, a};
      return '0;
   endfunction

   task automatic run_seq(input logic [1:0] g, input logic [1:0] b,
         input logic [AW-1:0] r, input bit m, input bit poke);
      int bad_des;
      logic [AW+6:0] e, a;
      string tag;
      bad_des = 0;
      @(negedge clk);
      tbg = g; tba = b; trow = r; wra = m; start = 1'b1;
      for (int k = 1; k <= K_DONE + 3; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke) begin
            tbg = ~g; tba = ~b; trow = ~r; wra = ~m;
            if (k == TM + 3 || k == K_ACT - 1) start = 1'b1;
         end
         e = exp_word(k, g, b, r, m);
         a = {cmd, bg, ba, addr};
         if (e[AW+6:AW+4] != 3'd0) begin
            if (k == 2) tag = "R2";
            else if (k == K_ACT) tag = poke ? "R9 R6" : "R6";
            else if (k == K_WR) tag = poke ? "R9 R7" : "R7";
            else tag = "R3 R4";
            chk(a == e, tag, a, e);
         end else if (a != '0) begin
            bad_des++;
            if (bad_des == 1) $display("FAIL R5 R9: stray word %0h at sample %0d, expected 0", a, k);
         end
         if (k == K_DONE) chk(done == 1'b1, "R8", done, 1);
         else if (done) begin
            bad_des++;
            $display("FAIL R8: done at sample %0d actual 1 expected 0", k);
         end
      end
      chk(bad_des == 0, "R5 DES between commands", bad_des, 0);
      start = 1'b0;
   endtask

   task automatic refuse_case(input bit bi, input bit di, input bit ci);
      int stray;
      stray = 0;
      @(negedge clk);
      bidle = bi; dbi = di; crc = ci; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err == 1'b1 && cmd == 3'd0, "R1 error pulse", {err, cmd}, 4'b1000);
      for (int k = 0; k < 3 * TM; k++) begin
         @(negedge clk);
         if (err || done || cmd != 3'd0) stray++;
      end
      chk(stray == 0, "R1 quiet after refusal", stray, 0);
      bidle = 1'b1; dbi = 1'b0; crc = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(cmd == 3'd0 && bg == 0 && ba == 0 && addr == 0 && !done && !err,
          "R10 reset state", {cmd, bg, ba, addr, done, err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cmd == 3'd0 && !done && !err, "R10 idle after reset", cmd, 0);

      run_seq(2'b11, 2'b10, 18'h2ABCD, 1'b1, 1'b0);
      run_seq(2'b00, 2'b01, 18'h3FFFF, 1'b0, 1'b0);
      run_seq(2'b01, 2'b11, 18'h00000, 1'b1, 1'b1);
      refuse_case(1'b0, 1'b0, 1'b0);
      refuse_case(1'b1, 1'b1, 1'b0);
      refuse_case(1'b1, 1'b0, 1'b1);
      for (int n = 0; n < 6; n++) begin
         run_seq(2'($urandom), 2'($urandom), AW'($urandom), 1'($urandom), 1'($urandom));
      end
      repeat (4) @(negedge clk);
      chk(cmd == 3'd0 && !done && !err, "R10 idle at end", cmd, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule